// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Transceiver

This block sends and receives asynchronous serial characters. Each character is framed by a low start bit and one high stop bit. The character length can be set from 1 to 8 data bits, and an even or odd parity bit can be added. The transmit side and the receive side each have their own 16-entry queue. Software loads characters into the transmit queue and drains received characters from the receive queue through a small register port. Each queue can raise an interrupt by comparing its fill count with a programmable level.

The bit rate comes from a 16-bit divisor that is written as two separate byte registers. Any non-zero divisor N gives one bit every (N+1)*8 clock cycles. A zero divisor falls back to one bit every 16 cycles. The serial engines stay idle until software sets a run bit, so software can finish the configuration first. Each queue can also be cleared on its own. The receiver samples the line at eight times the bit rate and confirms a start bit at its middle. It flags a missing stop bit and a character lost to a full queue.

Register map (addr, write / read): 0 control / control; 1 divisor high byte; 2 divisor low byte; 3 queue control (write) / receive count (read); 4 receive level; 5 transmit level; 6 push transmit character (write) / status (read); 7 pop receive character (read). Control bits: [0] transmit enable, [1] receive enable, [2] run, [3] parity enable, [4] odd parity, [7:5] data length minus one. Queue control bits: [0] clear transmit queue, [1] clear receive queue (both self-clearing), [2] transmit interrupt enable, [3] receive interrupt enable. Status bits: [7] transmit ready, [6] overrun, [5] framing error, [4:0] transmit count.

Top module: `uart_fifo_xcvr`

## Requirements
- R1: After reset, txd is high and both interrupts are low. Control reads 0xE0, the receive level reads 31, the receive count reads 0 and the status reads 0x80.
- R2: For a divisor N = {high byte, low byte} from 1 to 65535, every transmitted bit lasts (N+1)*8 clock cycles.
- R3: For a divisor of 0, every transmitted bit lasts 16 clock cycles.
- R4: A transmitted frame has a low start bit, then (length field + 1) data bits sent least significant first. When parity is enabled, a parity bit follows the data: it makes the count of ones even, or odd when bit 4 is set. The frame ends with one high stop bit, and the line idles high.
- R5: The transmit queue holds 16 characters, and pushes to a full queue are dropped. Status bit 7 is 1 exactly when the transmit count is below 16.
- R6: Each received frame with a valid stop bit is appended to the receive queue. Reads of address 7 return the characters oldest first, and each read removes one character.
- R7: rx_irq equals receive-interrupt enable AND (receive count >= receive level). The level resets to 31, so an enabled interrupt stays low after reset.
- R8: tx_irq equals transmit-interrupt enable AND (transmit count <= transmit level).
- R9: While the run bit is 0, txd stays high even when characters are queued. Setting the run bit starts transmission.
- R10: Writing 1 to queue-control bit 0 or bit 1 empties the transmit or the receive queue.
- R11: A frame whose stop bit is sampled low sets status bit 5 and is not stored.
- R12: A frame that arrives while the receive queue is full sets status bit 6 and is dropped. The 16 stored characters are kept unchanged.
- R13: With transmit enable at 0, queued characters are not sent. With receive enable at 0, the rxd line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops at address 7) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit queue level interrupt |
| rx_irq | output | 1 | Receive queue level interrupt |

## Verification
A wrong baud count shows on txd within one bit time, as a start bit that is too short or too long. A slipped bit counter or a bad parity calculation corrupts the first decoded frame. A queue pointer or count that goes wrong shows on the next read: the count register, the status bits or the interrupt pins disagree at once, and a bad pointer returns characters in the wrong order. A receiver that loses the start alignment stores a wrong character or raises a framing error within that same frame.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int DIV_W = 16;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_DIV_HI = 3'd1;
  localparam logic [2:0] A_DIV_LO = 3'd2;
  localparam logic [2:0] A_QCTRL  = 3'd3;
  localparam logic [2:0] A_RX_LVL = 3'd4;
  localparam logic [2:0] A_TX_LVL = 3'd5;
  localparam logic [2:0] A_TXSTAT = 3'd6;
  localparam logic [2:0] A_RXDATA = 3'd7;

  // clocks between oversample ticks (8 ticks per bit)
  function automatic logic [DIV_W:0] clocks_per_tick(input logic [DIV_W-1:0] div);
    return (div == '0) ? (DIV_W+1)'(2) : (DIV_W+1)'(div) + (DIV_W+1)'(1);
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic [2:0] len_m1,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++)
      if (i <= int'(len_m1)) p = p ^ d[i];
    return p;
  endfunction
endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          dropped
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != CW'(DEPTH)) || do_pop);
  assign dropped = push && !do_push;
  assign dout    = (count == '0) ? '0 : mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk)
    if (do_push && !clr) mem[wp] <= din;
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W:0] cnt, period;

  assign period = clocks_per_tick(div);
  assign tick   = run && (cnt >= period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       enable,
  input  logic       tick,
  input  logic [2:0] len_m1,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       have_data,
  input  logic [7:0] data,
  output logic       pop,
  output logic       txd
);
  logic       busy;
  logic [2:0] sub;
  logic [3:0] bits_left;
  logic [9:0] shreg, frame;

  always_comb begin
    frame = '1;
    for (int i = 0; i < 8; i++)
      if (i <= int'(len_m1)) frame[i] = data[i];
    frame[4'(len_m1) + 4'd1] = par_en ? parity_of(data, len_m1, par_odd) : 1'b1;
  end

  assign pop = run && tick && !busy && enable && have_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; txd <= 1'b1; sub <= '0; bits_left <= '0; shreg <= '1;
    end else if (!run) begin
      busy <= 1'b0; txd <= 1'b1; sub <= '0; bits_left <= '0;
    end else if (tick) begin
      if (!busy) begin
        if (pop) begin
          busy      <= 1'b1;
          txd       <= 1'b0;
          sub       <= '0;
          shreg     <= frame;
          bits_left <= 4'(len_m1) + 4'd2 + 4'(par_en);
        end
      end else begin
        sub <= sub + 1'b1;
        if (sub == 3'd7) begin
          if (bits_left == '0) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            txd       <= shreg[0];
            shreg     <= {1'b1, shreg[9:1]};
            bits_left <= bits_left - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       enable,
  input  logic       tick,
  input  logic       rxd,
  input  logic [2:0] len_m1,
  input  logic       par_en,
  output logic       push,
  output logic       frame_err,
  output logic [7:0] data
);
  logic       active, armed;
  logic [2:0] sub;
  logic [3:0] idx, last_idx;

  assign last_idx = 4'(len_m1) + 4'd1 + 4'(par_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; armed <= 1'b0; sub <= '0; idx <= '0;
      data <= '0; push <= 1'b0; frame_err <= 1'b0;
    end else begin
      push      <= 1'b0;
      frame_err <= 1'b0;
      if (!run || !enable) begin
        active <= 1'b0; armed <= 1'b0; sub <= '0;
      end else if (tick) begin
        if (!active) begin
          if (rxd) begin
            armed <= 1'b1; sub <= '0;
          end else if (armed) begin
            if (sub == 3'd3) begin
              active <= 1'b1; sub <= '0; idx <= '0; data <= '0;
            end else sub <= sub + 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
          if (sub == 3'd7) begin
            if (idx != last_idx) begin
              if (idx <= 4'(len_m1)) data[idx[2:0]] <= rxd;
              idx <= idx + 1'b1;
            end else begin
              active    <= 1'b0;
              armed     <= rxd;
              push      <= rxd;
              frame_err <= !rxd;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_fifo_xcvr.sv
module uart_fifo_xcvr
  import uart_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_irq,
  output logic       rx_irq
);
  logic [7:0]    ctrl_q, div_hi_q, div_lo_q;
  logic [CW-1:0] rx_lvl_q, tx_lvl_q;
  logic          tx_ie_q, rx_ie_q, ovr_q, ferr_q;
  logic          tx_clr, rx_clr, tx_push, rx_pop;
  logic          run, tick, tx_pop, rx_push, rx_ferr, rx_dropped, tx_dropped;
  logic [CW-1:0] tx_count, rx_count;
  logic [7:0]    tx_head, rx_head, rx_word;
  logic [1:0]    rx_sync;
  logic          tx_ready;

  assign run     = ctrl_q[2];
  assign tx_clr  = wr_en && (addr == A_QCTRL) && wdata[0];
  assign rx_clr  = wr_en && (addr == A_QCTRL) && wdata[1];
  assign tx_push = wr_en && (addr == A_TXSTAT);
  assign rx_pop  = rd_en && (addr == A_RXDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'hE0; div_hi_q <= '0; div_lo_q <= '0;
      rx_lvl_q <= '1; tx_lvl_q <= '0; tx_ie_q <= 1'b0; rx_ie_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:   ctrl_q   <= wdata;
        A_DIV_HI: div_hi_q <= wdata;
        A_DIV_LO: div_lo_q <= wdata;
        A_QCTRL:  begin tx_ie_q <= wdata[2]; rx_ie_q <= wdata[3]; end
        A_RX_LVL: rx_lvl_q <= wdata[CW-1:0];
        A_TX_LVL: tx_lvl_q <= wdata[CW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11; ovr_q <= 1'b0; ferr_q <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (!run || rx_clr) begin
        ovr_q <= 1'b0; ferr_q <= 1'b0;
      end else begin
        if (rx_dropped) ovr_q  <= 1'b1;
        if (rx_ferr)    ferr_q <= 1'b1;
      end
    end
  end

  uart_baud_gen u_baud (.clk, .rst_n, .run, .div({div_hi_q, div_lo_q}), .tick);

  uart_sync_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .clr(tx_clr), .push(tx_push), .din(wdata), .pop(tx_pop),
    .dout(tx_head), .count(tx_count), .dropped(tx_dropped));

  uart_sync_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .clr(rx_clr), .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_head), .count(rx_count), .dropped(rx_dropped));

  uart_tx_engine u_tx (
    .clk, .rst_n, .run, .enable(ctrl_q[0]), .tick, .len_m1(ctrl_q[7:5]),
    .par_en(ctrl_q[3]), .par_odd(ctrl_q[4]), .have_data(tx_count != '0),
    .data(tx_head), .pop(tx_pop), .txd);

  uart_rx_engine u_rx (
    .clk, .rst_n, .run, .enable(ctrl_q[1]), .tick, .rxd(rx_sync[1]),
    .len_m1(ctrl_q[7:5]), .par_en(ctrl_q[3]), .push(rx_push),
    .frame_err(rx_ferr), .data(rx_word));

  assign tx_ready = tx_count < CW'(FIFO_DEPTH);
  assign tx_irq   = tx_ie_q && (tx_count <= tx_lvl_q);
  assign rx_irq   = rx_ie_q && (rx_count >= rx_lvl_q);

  always_comb begin
    case (addr)
      A_CTRL:   rdata = ctrl_q;
      A_DIV_HI: rdata = div_hi_q;
      A_DIV_LO: rdata = div_lo_q;
      A_QCTRL:  rdata = 8'(rx_count);
      A_RX_LVL: rdata = 8'(rx_lvl_q);
      A_TX_LVL: rdata = 8'(tx_lvl_q);
      A_TXSTAT: rdata = {tx_ready, ovr_q, ferr_q, 5'(tx_count)};
      default:  rdata = rx_head;
    endcase
  end
endmodule

// File: rtl/uart_fifo_xcvr_chk.sv
module uart_fifo_xcvr_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          txd,
  input logic          tick,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_pop,
  input logic          tx_clr,
  input logic          rx_clr,
  input logic          rx_dropped,
  input logic          rx_ferr,
  input logic          ferr_q
);
  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !run |=> txd);
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  // R5
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_count <= CW'(DEPTH));
  // R5
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CW'(DEPTH) && !tx_pop && !tx_clr) |=> tx_count == CW'(DEPTH));
  // R12
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dropped |-> rx_count == CW'(DEPTH));
  // R11
  ferr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ferr && run && !rx_clr) |=> ferr_q);
endmodule

bind uart_fifo_xcvr uart_fifo_xcvr_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .txd(txd), .tick(tick),
  .tx_count(tx_count), .rx_count(rx_count), .tx_pop(tx_pop), .tx_clr(tx_clr),
  .rx_clr(rx_clr), .rx_dropped(rx_dropped), .rx_ferr(rx_ferr), .ferr_q(ferr_q));

// File: tb/sim_uart_fifo_xcvr.sv
`timescale 1ns/1ps
module sim_uart_fifo_xcvr;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd, tx_irq, rx_irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  byte unsigned rxq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_xcvr u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
                     .rxd, .txd, .tx_irq, .rx_irq);

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); addr = a; rd_en = 1'b0; #1 v = rdata;
  endtask

  task automatic pop(output int v);
    @(negedge clk); addr = 3'd7; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // clocks per bit from the divisor law, written directly
  function automatic int bit_clocks(input int div);
    if (div == 0) return 16;
    return (div + 1) * 8;
  endfunction

  function automatic bit par(input int d, input int len, input bit odd);
    return ($countones(d & ((1 << len) - 1)) % 2 == 1) ^ odd;
  endfunction

  task automatic expect_tx(input string req, input int d, input int len, input bit pen,
                           input bit odd, input int bclk, input bit dur_chk);
    int t = 0, nb, low_run = -1, got = 0;
    bit bits [16];
    while (txd !== 1'b0 && t < 60000) begin @(negedge clk); t++; end
    check({req, " frame seen"}, int'(t < 60000), 1);
    nb = len + 2 + int'(pen);
    for (int c = 0; c < nb * bclk; c++) begin
      if (c > 0) @(negedge clk);
      if (low_run < 0 && txd === 1'b1) low_run = c;
      if (c % bclk == bclk / 2) bits[c / bclk] = txd;
    end
    for (int i = 0; i < len; i++) got |= int'(bits[1 + i]) << i;
    check({req, " start"}, int'(bits[0]), 0);
    check({req, " data"}, got, d & ((1 << len) - 1));
    if (pen) check({req, " parity"}, int'(bits[1 + len]), int'(par(d, len, odd)));
    check({req, " stop"}, int'(bits[nb - 1]), 1);
    if (dur_chk) check({req, " start length"}, low_run, bclk);
  endtask

  task automatic send_rx(input int d, input int len, input bit pen, input bit odd,
                         input bit stop, input int bclk);
    @(negedge clk); rxd = 1'b0;
    repeat (bclk) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rxd = d[i]; repeat (bclk) @(negedge clk);
    end
    if (pen) begin rxd = par(d, len, odd); repeat (bclk) @(negedge clk); end
    rxd = stop; repeat (bclk) @(negedge clk);
    rxd = 1'b1; repeat (2 * bclk) @(negedge clk);
  endtask

  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (txd === 1'b0) lows++; end
  endtask

  initial begin
    repeat (170000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v, lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 txd", int'(txd), 1);
    check("R1 tx_irq", int'(tx_irq), 0);
    check("R1 rx_irq", int'(rx_irq), 0);
    rd(3'd0, v); check("R1 control", v, 8'hE0);
    rd(3'd4, v); check("R1 rx level", v, 31);
    rd(3'd3, v); check("R1 rx count", v, 0);
    rd(3'd6, v); check("R1 status", v, 8'h80);

    // R9: queued data held while run=0
    wr(3'd1, 8'h00); wr(3'd2, 8'h03);
    wr(3'd0, 8'hE1);
    wr(3'd6, 8'hA5); wr(3'd6, 8'h3C); wr(3'd6, 8'h81);
    count_low(300, lows); check("R9 txd held high", lows, 0);
    rd(3'd6, v); check("R9 queued count", v & 8'h1F, 3);
    wr(3'd0, 8'hE5);
    expect_tx("R2 R4 byte0", 8'hA5, 8, 0, 0, 32, 1);
    expect_tx("R4 byte1", 8'h3C, 8, 0, 0, 32, 0);
    expect_tx("R4 byte2", 8'h81, 8, 0, 0, 32, 0);
    rd(3'd6, v); check("R5 drained count", v & 8'h1F, 0);

    // R4 parity and length
    wr(3'd0, 8'hED); wr(3'd6, 8'h07);
    expect_tx("R4 even parity", 8'h07, 8, 1, 0, 32, 0);
    wr(3'd0, 8'hFD); wr(3'd6, 8'h03);
    expect_tx("R4 odd parity", 8'h03, 8, 1, 1, 32, 0);
    wr(3'd0, 8'h85); wr(3'd6, 8'h35);
    expect_tx("R4 five bits", 8'h35, 5, 0, 0, 32, 0);

    // R3 zero divisor, R2 high byte
    wr(3'd0, 8'hE5); wr(3'd2, 8'h00); wr(3'd6, 8'h55);
    expect_tx("R3 div zero", 8'h55, 8, 0, 0, bit_clocks(0), 1);
    wr(3'd1, 8'h01); wr(3'd6, 8'h01);
    expect_tx("R2 div 0x0100", 8'h01, 8, 0, 0, bit_clocks(256), 1);
    wr(3'd1, 8'h00); wr(3'd2, 8'h03);

    // R13 transmit disabled
    wr(3'd0, 8'hE4); wr(3'd6, 8'h11);
    count_low(400, lows); check("R13 tx disabled line", lows, 0);
    rd(3'd6, v); check("R13 tx disabled count", v & 8'h1F, 1);
    wr(3'd3, 8'h01);
    rd(3'd6, v); check("R10 tx clear", v & 8'h1F, 0);

    // R5 overflow, R8 tx interrupt
    wr(3'd0, 8'hE1); wr(3'd5, 8'h02); wr(3'd3, 8'h04);
    for (int i = 0; i < 18; i++) wr(3'd6, 8'(i));
    rd(3'd6, v); check("R5 full status", v, 8'h10);
    check("R8 tx_irq full", int'(tx_irq), 0);
    wr(3'd3, 8'h05);
    check("R8 tx_irq empty", int'(tx_irq), 1);
    for (int i = 0; i < 3; i++) wr(3'd6, 8'(i));
    check("R8 tx_irq above level", int'(tx_irq), 0);
    wr(3'd3, 8'h01);

    // R6, R7 receive
    wr(3'd0, 8'hE6); wr(3'd3, 8'h08);
    send_rx(8'h12, 8, 0, 0, 1, 32); rxq.push_back(8'h12);
    send_rx(8'h34, 8, 0, 0, 1, 32); rxq.push_back(8'h34);
    rd(3'd3, v); check("R6 rx count", v, 2);
    check("R7 rx_irq default level", int'(rx_irq), 0);
    wr(3'd4, 8'd2); check("R7 rx_irq level 2", int'(rx_irq), 1);
    wr(3'd4, 8'd3); check("R7 rx_irq level 3", int'(rx_irq), 0);
    while (rxq.size() > 0) begin
      pop(v); check("R6 rx order", v, int'(rxq.pop_front()));
    end
    rd(3'd3, v); check("R6 rx drained", v, 0);

    // R11 framing error
    send_rx(8'h5A, 8, 0, 0, 0, 32);
    rd(3'd6, v); check("R11 ferr status", v, 8'hA0);
    rd(3'd3, v); check("R11 not stored", v, 0);
    wr(3'd3, 8'h0A);
    rd(3'd6, v); check("R10 rx clear flags", v, 8'h80);

    // R12 overrun
    for (int i = 0; i < 17; i++) begin
      send_rx(8'h40 + i, 8, 0, 0, 1, 32);
      if (i < 16) rxq.push_back(8'(8'h40 + i));
    end
    rd(3'd3, v); check("R12 rx count full", v, 16);
    rd(3'd6, v); check("R12 overrun status", v, 8'hC0);
    while (rxq.size() > 0) begin
      pop(v); check("R12 kept data", v, int'(rxq.pop_front()));
    end

    // R13 receive disabled
    wr(3'd3, 8'h02); wr(3'd0, 8'hE4);
    send_rx(8'h77, 8, 0, 0, 1, 32);
    rd(3'd3, v); check("R13 rx disabled", v, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule